// File: doc/BRIEF.md
# Acknowledged Output Handshake Port

This block is a latched parallel output port whose transfers are paced by the receiving peripheral. A CPU write strobe captures a data word into an output latch and pulls the active-low buffer-full line. The peripheral takes the word, then returns a low pulse on its acknowledge line. The falling edge of that pulse releases buffer-full. The rising edge can raise an interrupt that asks the CPU for the next word.

The CPU side is synchronous to the block clock and gives a single-cycle write strobe, the data word and an interrupt-enable bit. It receives an interrupt request and two status bits: buffer full and a sticky overrun flag. The peripheral side is the held data word, the buffer-full line and the asynchronous acknowledge input. The acknowledge goes through a flip-flop synchronizer before edge detection. Mapping these signals onto shared port pins is left to a surrounding wrapper.

Top module: `ackport`

## Requirements
- R1: While reset is asserted and right after it, `obf_n` is 1, `irq` is 0, `stat_ovr` is 0, `stat_full` is 0 and `pdata` is all zeros.
- R2: A clock edge with `wr_en`=1 loads `wr_data` into `pdata` and drives `obf_n` to 0. Both values are visible after that same edge.
- R3: `pdata` changes only at an edge where `wr_en` is 1. Acknowledge activity never alters it.
- R4: With the default two synchronizer stages, `obf_n` returns to 1 after the third rising clock edge that samples `ack_n` low following a high level. Until then it stays 0.
- R5: With the default two synchronizer stages, `irq` becomes 1 after the third rising clock edge that samples `ack_n` high following a low level. This happens when `obf_n` is 1 and `int_en` is 1 at that edge.
- R6: When `int_en` is 0 at the edge where the acknowledge rise is detected, `irq` stays 0.
- R7: A write clears `irq`, and `irq` is 0 after the write edge.
- R8: A write made while `obf_n` is 0 sets `stat_ovr` to 1. The flag then holds 1 until reset. A write made while `obf_n` is 1 leaves `stat_ovr` unchanged.
- R9: When a write and a detected acknowledge fall occur at the same edge, the write takes priority. `obf_n` stays 0 and `pdata` takes the new word.
- R10: `stat_full` is 1 exactly when `obf_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| wr_en | input | 1 | CPU write strobe, one cycle per word |
| wr_data | input | DATA_W | Word written by the CPU |
| int_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request to the CPU, active high |
| stat_full | output | 1 | Status: word pending at the peripheral |
| stat_ovr | output | 1 | Status: sticky overrun flag |
| pdata | output | DATA_W | Held output word to the peripheral |
| obf_n | output | 1 | Output buffer full, active low |
| ack_n | input | 1 | Acknowledge from the peripheral, active low, asynchronous |

## Verification
The bench uses the default 8-bit word and two synchronizer stages. This small configuration lets it send every one of the 256 codes through a full write and acknowledge handshake. Interrupt enable alternates with the low bit of each code, so both the enabled and masked interrupt paths are covered across the whole sweep. The two-stage default fixes the acknowledge latency at three edges, and the bench checks the cycle before and the cycle of each release and interrupt. Further directed cases cover repeated writes for overrun, a write landing on the same edge as the acknowledge release, and a second reset.

// File: rtl/ackport_pkg.sv
package ackport_pkg;

  // Edge events extracted from the synchronized acknowledge line
  typedef struct packed {
    logic fall;
    logic rise;
  } ack_evt_t;

  // Control state held by the handshake controller
  typedef struct packed {
    logic obf_n;
    logic irq;
    logic ovr;
  } ctl_state_t;

  localparam ctl_state_t CTL_RESET = '{obf_n: 1'b1, irq: 1'b0, ovr: 1'b0};

endpackage

// File: rtl/ackport_sync.sv
module ackport_sync #(
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  async_in,
  output ackport_pkg::ack_evt_t evt
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;
  logic          prev_q;
  logic          prev_d;

  // Shift path written out stage by stage
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = async_in;
      end else begin : g_rest
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  assign prev_d = chain_q[LAST];

  // Idle level of the acknowledge line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  always_comb begin
    evt.fall = prev_q & ~chain_q[LAST];
    evt.rise = ~prev_q & chain_q[LAST];
  end

endmodule

// File: rtl/ackport_latch.sv
module ackport_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load) begin
      word_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign dout = word_q;

endmodule

// File: rtl/ackport_ctrl.sv
module ackport_ctrl (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic                  int_en,
  input  ackport_pkg::ack_evt_t evt,
  output logic                  obf_n,
  output logic                  irq,
  output logic                  ovr
);

  import ackport_pkg::*;

  ctl_state_t st_q;
  ctl_state_t st_d;

  // Next-state: a write outranks any acknowledge event in the same cycle
  always_comb begin
    st_d = st_q;
    if (wr) begin
      st_d.obf_n = 1'b0;
      st_d.irq   = 1'b0;
      if (!st_q.obf_n) begin
        st_d.ovr = 1'b1;
      end
    end else begin
      if (evt.fall) begin
        st_d.obf_n = 1'b1;
      end
      if (evt.rise && st_q.obf_n && int_en) begin
        st_d.irq = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CTL_RESET;
    end else begin
      st_q <= st_d;
    end
  end

  assign obf_n = st_q.obf_n;
  assign irq   = st_q.irq;
  assign ovr   = st_q.ovr;

endmodule

// File: rtl/ackport.sv
module ackport #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              int_en,
  output logic              irq,
  output logic              stat_full,
  output logic              stat_ovr,
  output logic [DATA_W-1:0] pdata,
  output logic              obf_n,
  input  logic              ack_n
);

  import ackport_pkg::*;

  ack_evt_t ack_evt;
  logic     obf_n_int;

  ackport_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ack_n),
    .evt     (ack_evt)
  );

  ackport_latch #(
    .DATA_W(DATA_W)
  ) u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .load (wr_en),
    .din  (wr_data),
    .dout (pdata)
  );

  ackport_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_en),
    .int_en(int_en),
    .evt   (ack_evt),
    .obf_n (obf_n_int),
    .irq   (irq),
    .ovr   (stat_ovr)
  );

  assign obf_n     = obf_n_int;
  assign stat_full = ~obf_n_int;

endmodule

// File: rtl/ackport_chk.sv
module ackport_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              int_en,
  input logic              irq,
  input logic              stat_full,
  input logic              stat_ovr,
  input logic [DATA_W-1:0] pdata,
  input logic              obf_n
);

  p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!obf_n && pdata == $past(wr_data)));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pdata));

  p_release_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf_n) |-> $past(!wr_en));

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(int_en) && $past(obf_n) && !$past(wr_en)));

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ovr |=> stat_ovr);

  p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ovr) |-> ($past(wr_en) && !$past(obf_n)));

  p_full_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_full == !obf_n);

endmodule

bind ackport ackport_chk #(
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .int_en   (int_en),
  .irq      (irq),
  .stat_full(stat_full),
  .stat_ovr (stat_ovr),
  .pdata    (pdata),
  .obf_n    (obf_n)
);

// File: tb/ackport_tb.sv
module ackport_tb;

  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          int_en;
  logic          irq;
  logic          stat_full;
  logic          stat_ovr;
  logic [DW-1:0] pdata;
  logic          obf_n;
  logic          ack_n;

  int n_chk;
  int n_err;
  bit done;

  ackport #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .int_en(int_en), .irq(irq), .stat_full(stat_full), .stat_ovr(stat_ovr),
    .pdata(pdata), .obf_n(obf_n), .ack_n(ack_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [DW-1:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic check_reset_state();
    chk("R1 obf_n", obf_n, 1);
    chk("R1 irq", irq, 0);
    chk("R1 ovr", stat_ovr, 0);
    chk("R1 full", stat_full, 0);
    chk("R1 pdata", pdata, 0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();
  endtask

  initial begin
    n_chk   = 0;
    n_err   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    int_en  = 1'b0;
    ack_n   = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // Full handshake for every code; interrupt enable follows bit 0
    for (int v = 0; v < 256; v++) begin
      logic en;
      en = v[0];
      int_en = en;
      do_write(v[DW-1:0]);
      chk("R2 pdata", pdata, v);
      chk("R2 obf_n", obf_n, 0);
      chk("R10 full", stat_full, 1);
      chk("R7 irq cleared", irq, 0);
      chk("R8 no overrun", stat_ovr, 0);
      // ack low: release after the third edge
      ack_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R4 still full", obf_n, 0);
      chk("R3 hold", pdata, v);
      @(negedge clk);
      chk("R4 released", obf_n, 1);
      chk("R10 empty", stat_full, 0);
      ack_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R5 irq not yet", irq, 0);
      @(negedge clk);
      if (en) chk("R5 irq raised", irq, 1);
      else    chk("R6 irq masked", irq, 0);
      chk("R3 hold after ack", pdata, v);
    end

    // R7: write clears a pending interrupt
    int_en = 1'b1;
    chk("R7 irq pending", irq, 1);
    do_write(8'h3C);
    chk("R7 irq after write", irq, 0);
    chk("R8 clean write", stat_ovr, 0);

    // R8: second write while still full
    do_write(8'hA5);
    chk("R8 overrun set", stat_ovr, 1);
    chk("R2 second word", pdata, 8'hA5);
    // sticky across acknowledge handshakes
    ack_n = 1'b0;
    repeat (3) @(negedge clk);
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 overrun sticky", stat_ovr, 1);
    chk("R3 hold on ack", pdata, 8'hA5);

    // R1 again after a second reset
    apply_reset();

    // R9: write on the same edge as the detected ack fall
    do_write(8'h11);
    @(negedge clk);
    ack_n  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = 8'h77;
    @(negedge clk);
    wr_en   = 1'b0;
    chk("R9 obf_n stays low", obf_n, 0);
    chk("R9 new word", pdata, 8'h77);
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 still full", obf_n, 0);
    chk("R5 no irq while full", irq, 0);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule